// File: doc/BRIEF.md
# Serial Debug Command Port

This block is the target-side end of a bit-serial debug link. An external controller clocks frames into it over a serial clock and a data-in line. Each frame starts with an 8-bit command byte. Depending on the command's class, the byte is followed by 24 data bits written into a debug register, by 24 data bits read back out of one, or by nothing. An acknowledge line tells the controller that the target has entered debug mode, and it tells the controller that each command has finished. The controller must wait for that acknowledge before it starts, and again before each new command.

The block runs on the system clock. It samples the serial clock as a slow, already-synchronous input and acts on its detected edges. On the inside it offers a plain register port: a register select, a read strobe with returned data, a write strobe with data, and a pulse for commands that carry no data. The register file reports through a flag whether the selected register is a narrow 16-bit one. A narrow register travels in the upper 16 bits of the 24-bit field, and the low 8 bits of that field are zero.

Top module: `dbg_serial_port`

## Requirements
- R1: While `dbg_mode` is low, `ack` stays low. One system clock after `dbg_mode` rises, `ack` goes high to announce debug entry.
- R2: Command byte encoding: bit 6 = 1 marks a no-data command, and it takes priority. Otherwise bit 7 = 1 means read and bit 7 = 0 means write. Bits 4:0 are the register select. Bit 5 is ignored.
- R3: `sdi` is sampled on each rising edge of `sclk`. Command and data are both shifted most significant bit first.
- R4: On a read, `reg_rd` pulses for one clock with `reg_sel` set to the select field. The 24-bit word is then driven on `sdo` MSB first. Each bit changes on a falling `sclk` edge, so the first bit is valid before the first data rising edge.
- R5: On a write, after the 24th data bit, `reg_wr` pulses for exactly one clock with `reg_sel` and the received word.
- R6: On a no-data command, `exec_go` pulses for one clock with `reg_sel` right after the command byte, and `ack` follows without any data phase.
- R7: When `reg_narrow` is high, a read sends `{reg_rdata[15:0], 8'h00}` and a write stores `{8'h00, frame[23:8]}`.
- R8: `ack` rises after the last bit of a frame, or on debug entry. It stays high until the second falling `sclk` edge after it rose.
- R9: Rising `sclk` edges while `ack` is high are discarded. The next frame starts only after `ack` falls.
- R10: Low `dbg_mode` discards all input, holds `sdo`, `ack` and every strobe low, and returns the command shifter to its idle state.
- R11: After reset, `ack`, `sdo`, `reg_rd`, `reg_wr` and `exec_go` are all low.
- R12: At most one of `reg_rd`, `reg_wr` and `exec_go` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_mode | input | 1 | High while the core is in debug mode |
| sclk | input | 1 | Serial clock from the controller, slow and synchronous to clk |
| sdi | input | 1 | Serial data from the controller |
| sdo | output | 1 | Serial data to the controller |
| ack | output | 1 | Debug-entry and command-done acknowledge |
| reg_sel | output | 5 | Register select from the command byte |
| reg_rd | output | 1 | One-clock read strobe |
| reg_rdata | input | 24 | Read data of the selected register, valid while reg_rd is high |
| reg_narrow | input | 1 | Selected register is 16 bits wide |
| reg_wr | output | 1 | One-clock write strobe |
| reg_wdata | output | 24 | Write data, already justified |
| exec_go | output | 1 | One-clock pulse for a no-data command |

## Verification
The properties assume that `sclk` is synchronous to `clk` and holds each level for several system clocks. This makes every serial edge show up as a single-cycle event, and a rise and a fall never fall in the same cycle. They also assume that the register file answers `reg_rdata` and `reg_narrow` combinationally from `reg_sel`. The stimulus holds each `sclk` level for many clocks and only ever drives inputs on falling `clk` edges. Its register model answers in the same cycle. Random commands come only as whole frames, except in the directed cases that deliberately cut a frame off by dropping debug mode.

// File: rtl/dbg_serial_pkg.sv
// Shared types for the serial debug port.
// Assumes: nothing beyond IEEE 1800-2017 synthesis support for enums.
package dbg_serial_pkg;

    // Frame phases of the serial engine.
    typedef enum logic [2:0] {
        ST_OFF,     // not in debug mode
        ST_CMD,     // shifting the command byte
        ST_RLOAD,   // one clock: fetch read data
        ST_RDATA,   // shifting read data out
        ST_WDATA,   // shifting write data in
        ST_WSTORE,  // one clock: write strobe
        ST_EXEC,    // one clock: no-data command strobe
        ST_ACK      // acknowledge pending, input discarded
    } phase_e;

endpackage

// File: rtl/dbg_serial_edge.sv
// Edge detector for the serial clock.
// Assumes sclk is already synchronous to clk and holds each level for
// at least two clk cycles, so every edge becomes a one-cycle pulse.
module dbg_serial_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);

    logic sclk_q;

    // Remember last sampled level of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;

endmodule

// File: rtl/dbg_serial_align.sv
// Justifies narrow registers inside the wide data field.
// Assumes NARROW_W < DATA_W; narrow values sit in the upper bits of the
// field and the remaining low bits are zero.
module dbg_serial_align #(
    parameter int DATA_W   = 24,
    parameter int NARROW_W = 16
) (
    input  logic              narrow,
    input  logic [DATA_W-1:0] rd_raw,
    input  logic [DATA_W-1:0] wr_frame,
    output logic [DATA_W-1:0] rd_frame,
    output logic [DATA_W-1:0] wr_value
);

    localparam int PAD_W = DATA_W - NARROW_W;

    // Read path: move the narrow value to the top of the field.
    always_comb begin
        if (narrow) rd_frame = {rd_raw[NARROW_W-1:0], {PAD_W{1'b0}}};
        else        rd_frame = rd_raw;
    end

    // Write path: take the narrow value back from the top of the field.
    always_comb begin
        if (narrow) wr_value = {{PAD_W{1'b0}}, wr_frame[DATA_W-1:PAD_W]};
        else        wr_value = wr_frame;
    end

endmodule

// File: rtl/dbg_serial_port.sv
// Target-side serial debug command engine.
// Shifts in a command byte MSB first, then moves a data word in or out,
// or none, and raises ack at debug entry and when each command completes.
// Assumes sclk is slow and synchronous to clk, and that the register file
// answers reg_rdata/reg_narrow combinationally from reg_sel.
module dbg_serial_port
    import dbg_serial_pkg::*;
#(
    parameter int CMD_W    = 8,
    parameter int DATA_W   = 24,
    parameter int NARROW_W = 16,
    parameter int SEL_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_mode,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              ack,
    output logic [SEL_W-1:0]  reg_sel,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_narrow,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              exec_go
);

    localparam int CNT_W   = $clog2(DATA_W + 1);
    localparam int RD_BIT  = CMD_W - 1;   // read/write class bit
    localparam int ND_BIT  = CMD_W - 2;   // no-data class bit
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    phase_e             phase;
    logic [CNT_W-1:0]   bit_cnt;
    logic [CMD_W-2:0]   cmd_sr;     // earlier command bits, newest at bit 0
    logic [SEL_W-1:0]   sel_q;
    logic [DATA_W-1:0]  in_sr;
    logic [DATA_W-1:0]  out_sr;
    logic [DATA_W-1:0]  rd_frame;
    logic               sdo_q;
    logic               ack_half;   // first falling edge in ACK already seen
    logic               dbg_q;
    logic               rise;
    logic               fall;

    dbg_serial_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (rise),
        .fall  (fall)
    );

    dbg_serial_align #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_align (
        .narrow   (reg_narrow),
        .rd_raw   (reg_rdata),
        .wr_frame (in_sr),
        .rd_frame (rd_frame),
        .wr_value (reg_wdata)
    );

    // Frame sequencer: command shift, data phase, strobes and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= ST_OFF;
            bit_cnt  <= '0;
            cmd_sr   <= '0;
            sel_q    <= '0;
            in_sr    <= '0;
            out_sr   <= '0;
            sdo_q    <= 1'b0;
            ack_half <= 1'b0;
            dbg_q    <= 1'b0;
        end else begin
            dbg_q <= dbg_mode;
            if (!dbg_mode) begin
                phase   <= ST_OFF;
                bit_cnt <= '0;
                sdo_q   <= 1'b0;
            end else begin
                case (phase)
                    ST_OFF: begin
                        if (!dbg_q) begin
                            phase    <= ST_ACK;
                            ack_half <= 1'b0;
                        end
                    end
                    ST_CMD: begin
                        if (rise) begin
                            cmd_sr <= {cmd_sr[CMD_W-3:0], sdi};
                            if (bit_cnt == CMD_LAST) begin
                                bit_cnt <= '0;
                                sel_q   <= {cmd_sr[SEL_W-2:0], sdi};
                                if (cmd_sr[ND_BIT-1])      phase <= ST_EXEC;
                                else if (cmd_sr[RD_BIT-1]) phase <= ST_RLOAD;
                                else                       phase <= ST_WDATA;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RLOAD: begin
                        out_sr <= rd_frame;
                        phase  <= ST_RDATA;
                    end
                    ST_RDATA: begin
                        if (fall) begin
                            sdo_q  <= out_sr[DATA_W-1];
                            out_sr <= {out_sr[DATA_W-2:0], 1'b0};
                        end
                        if (rise) begin
                            if (bit_cnt == DATA_LAST) begin
                                bit_cnt  <= '0;
                                phase    <= ST_ACK;
                                ack_half <= 1'b0;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (rise) begin
                            in_sr <= {in_sr[DATA_W-2:0], sdi};
                            if (bit_cnt == DATA_LAST) begin
                                bit_cnt <= '0;
                                phase   <= ST_WSTORE;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_WSTORE, ST_EXEC: begin
                        phase    <= ST_ACK;
                        ack_half <= 1'b0;
                    end
                    ST_ACK: begin
                        if (fall) begin
                            sdo_q <= 1'b0;
                            if (ack_half) begin
                                phase   <= ST_CMD;
                                bit_cnt <= '0;
                            end else begin
                                ack_half <= 1'b1;
                            end
                        end
                    end
                    default: phase <= ST_OFF;
                endcase
            end
        end
    end

    assign sdo     = sdo_q;
    assign ack     = (phase == ST_ACK);
    assign reg_sel = sel_q;
    assign reg_rd  = (phase == ST_RLOAD);
    assign reg_wr  = (phase == ST_WSTORE);
    assign exec_go = (phase == ST_EXEC);

endmodule

// File: rtl/dbg_serial_port_chk.sv
// Property checker for dbg_serial_port, attached by bind.
// Assumes the same slow, synchronous sclk as the design.
module dbg_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic dbg_mode,
    input logic sclk,
    input logic sdo,
    input logic ack,
    input logic reg_rd,
    input logic reg_wr,
    input logic exec_go
);

    logic sclk_p;

    // Own copy of the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_p <= 1'b0;
        else        sclk_p <= sclk;
    end

    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rd, reg_wr, exec_go}));

    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_mode |=> (!ack && !sdo && !reg_rd && !reg_wr && !exec_go));

    p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && dbg_mode && !(sclk_p && !sclk)) |=> ack);

    p_ack_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!reg_rd && !reg_wr && !exec_go));

    p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode && !(sclk_p && !sclk)) |=> $stable(sdo));

    p_ack_needs_dbg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> dbg_mode);

endmodule

bind dbg_serial_port dbg_serial_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_mode (dbg_mode),
    .sclk     (sclk),
    .sdo      (sdo),
    .ack      (ack),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .exec_go  (exec_go)
);

// File: tb/dbg_serial_port_tb.sv
module dbg_serial_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        ack;
    logic [4:0]  reg_sel;
    logic        reg_rd;
    logic [23:0] reg_rdata;
    logic        reg_narrow;
    logic        reg_wr;
    logic [23:0] reg_wdata;
    logic        exec_go;

    logic [23:0] regs [32];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    int          ex_cnt = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dbg_serial_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dbg_mode   (dbg_mode),
        .sclk       (sclk),
        .sdi        (sdi),
        .sdo        (sdo),
        .ack        (ack),
        .reg_sel    (reg_sel),
        .reg_rd     (reg_rd),
        .reg_rdata  (reg_rdata),
        .reg_narrow (reg_narrow),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .exec_go    (exec_go)
    );

    // Register file model: upper half of the select space is narrow (R7).
    assign reg_rdata  = regs[reg_sel];
    assign reg_narrow = reg_sel[4];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) regs[i] <= 24'(i * 24'h030507) ^ 24'hA5C3E1;
        end else if (reg_wr) begin
            regs[reg_sel] <= reg_wdata;
        end
        if (rst_n && reg_wr)  wr_cnt <= wr_cnt + 1;
        if (rst_n && reg_rd)  rd_cnt <= rd_cnt + 1;
        if (rst_n && exec_go) ex_cnt <= ex_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] rd_expect(input logic [4:0] s, input logic [23:0] v);
        return s[4] ? {v[15:0], 8'h00} : v;
    endfunction

    function automatic logic [23:0] wr_expect(input logic [4:0] s, input logic [23:0] f);
        return s[4] ? {8'h00, f[23:8]} : f;
    endfunction

    task automatic sbit(input logic b, output logic o);
        sdi = b;
        repeat (4) @(negedge clk);
        o = sdo;
        sclk = 1'b1;
        repeat (8) @(negedge clk);
        sclk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] c);
        logic o;
        for (int i = 7; i >= 0; i--) sbit(c[i], o);
    endtask

    task automatic release_ack();
        logic o;
        sbit(1'b1, o);
    endtask

    task automatic do_write(input logic [7:0] c, input logic [23:0] d);
        logic o;
        send_cmd(c);
        for (int i = 23; i >= 0; i--) sbit(d[i], o);
    endtask

    task automatic do_read(input logic [7:0] c, output logic [23:0] d);
        logic o;
        send_cmd(c);
        d = '0;
        for (int i = 0; i < 24; i++) begin
            sbit(1'b0, o);
            d = {d[22:0], o};
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic [23:0] got;
        logic [23:0] exp;
        logic [4:0]  s;
        logic [23:0] d;
        int          w0;
        logic        o;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!ack && !sdo && !reg_rd && !reg_wr && !exec_go, "R11 idle after reset",
              {ack, sdo, reg_rd, reg_wr, exec_go}, 0);

        // R10 frames while out of debug mode are discarded
        w0 = wr_cnt;
        do_write(8'h03, 24'h111111);
        check(wr_cnt == w0 && !ack, "R10 ignored when off", wr_cnt - w0, 0);
        check(regs[3] == (24'(3 * 24'h030507) ^ 24'hA5C3E1), "R10 register untouched",
              regs[3], 24'(3 * 24'h030507) ^ 24'hA5C3E1);

        // R1 debug entry acknowledge
        dbg_mode = 1'b1;
        repeat (3) @(negedge clk);
        check(ack, "R1 ack on debug entry", ack, 1);
        sbit(1'b1, o);
        check(ack, "R8 ack holds over first falling edge", ack, 1);
        sbit(1'b1, o);
        check(!ack, "R8 ack clears on second falling edge", ack, 0);

        // R5 R3 wide write
        w0 = wr_cnt;
        do_write(8'h03, 24'hABCDEF);
        check(wr_cnt == w0 + 1, "R5 one write strobe", wr_cnt - w0, 1);
        check(regs[3] == 24'hABCDEF, "R3 R5 MSB-first write data", regs[3], 24'hABCDEF);
        check(ack, "R8 ack after last data bit", ack, 1);
        release_ack();
        check(!ack, "R8 ack released", ack, 0);

        // R4 wide read, R2 bit 5 ignored
        do_read(8'hA3, got);
        check(got == 24'hABCDEF, "R4 R2 read back", got, 24'hABCDEF);
        release_ack();

        // R7 narrow write and read
        do_write(8'h14, 24'h123456);
        check(regs[20] == 24'h001234, "R7 narrow write justified", regs[20], 24'h001234);
        release_ack();
        do_read(8'h94, got);
        check(got == 24'h123400, "R7 narrow read justified", got, 24'h123400);
        release_ack();

        // R6 no-data command, bit 7 set too (bit 6 has priority)
        w0 = ex_cnt;
        send_cmd(8'hC5);
        check(ex_cnt == w0 + 1, "R6 exec pulse", ex_cnt - w0, 1);
        check(ack, "R6 ack right after command byte", ack, 1);
        check(rd_cnt == 2, "R2 no-data takes priority over read", rd_cnt, 2);
        // R9 bits during ack discarded: a stray '1' must not shift in
        sbit(1'b1, o);
        do_read(8'h83, got);
        check(got == 24'hABCDEF, "R9 stray bit during ack dropped", got, 24'hABCDEF);
        release_ack();

        // R10 dropping debug mode mid-command restarts the shifter
        sbit(1'b1, o); sbit(1'b0, o); sbit(1'b1, o);
        dbg_mode = 1'b0;
        repeat (3) @(negedge clk);
        check(!ack && !sdo, "R10 outputs low when off", {ack, sdo}, 0);
        dbg_mode = 1'b1;
        repeat (3) @(negedge clk);
        sbit(1'b0, o); sbit(1'b0, o);
        do_read(8'h83, got);
        check(got == 24'hABCDEF, "R10 shifter back to idle", got, 24'hABCDEF);
        release_ack();

        // Constrained random frames against the model
        void'($urandom(32'h5EED1234));
        for (int n = 0; n < 24; n++) begin
            s = 5'($urandom_range(0, 31));
            d = 24'($urandom);
            if ($urandom_range(0, 1) == 1) begin
                exp = wr_expect(s, d);
                do_write({3'b000, s}, d);
                check(regs[s] == exp, "R5 R7 random write", regs[s], exp);
            end else begin
                exp = rd_expect(s, regs[s]);
                do_read({3'b100, s}, got);
                check(got == exp, "R4 R7 random read", got, exp);
            end
            release_ack();
        end

        finish_run();
    end

endmodule